// File: doc/BRIEF.md
# TLB Random Replacement Index Generator

This block supplies a pseudo-random slot number for TLB replacement. Slots below a programmable wired floor are protected, so every index it returns lies between that floor and the last TLB slot. A 32-bit linear congruential state moves forward once for each accepted request. The upper half of the new state is reduced modulo the count of unprotected slots, and the floor is added to the remainder.

The reduction is done by a bit-serial restoring remainder unit, so the slot count does not have to be a power of two. A request is accepted only while the block is idle. The answer appears a fixed number of cycles later, together with a one-cycle valid pulse. Requests that arrive while a reduction is in flight are dropped and do not move the state. The reset input is asynchronous and active low. Inside the block, reset release is synchronised to the clock over two flops.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset, `valid_o` and `busy_o` are 0 and `idx_o` is 0. The state register restarts from zero, so the first accepted request after any reset returns exactly the sampled wired value.
- R2: Each accepted request replaces the 32-bit state S by (S × 314159 + 1) mod 2^32. Nothing else changes S.
- R3: When the sampled wired value W is below N_ENTRIES, the returned index equals ((S_new >> 16) mod (N_ENTRIES − W)) + W, where S_new is the updated state.
- R4: Every index returned with W below N_ENTRIES satisfies W ≤ idx_o < N_ENTRIES.
- R5: `valid_o` rises exactly 16 rising edges after the edge that accepts a request (SEED_W − SEED_SHIFT). It stays high for exactly one cycle, and `idx_o` holds the result while it is high.
- R6: A request asserted while `busy_o` is 1 is ignored. It does not advance the state and produces no extra result.
- R7: When the sampled wired value is at or above N_ENTRIES, the index returned is N_ENTRIES − 1. The state still advances.
- R8: The wired value is sampled on the accepting edge. Changing `wired_i` while busy has no effect on the pending result.
- R9: `busy_o` is 1 from the edge after acceptance until the result edge. `busy_o` is 0 in the cycle in which `valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, accepted when not busy |
| wired_i | input | WIRED_W | Wired floor, sampled at acceptance |
| idx_o | output | clog2(N_ENTRIES) | Replacement index, valid with valid_o |
| valid_o | output | 1 | One-cycle result pulse |
| busy_o | output | 1 | Reduction in progress; requests dropped |

## Verification
The assertions assume that `req_i` and `wired_i` are driven clean, with no unknown values, in every cycle after the internal reset releases. They also assume that no request is raised during the two cycles in which that release is synchronised. The bench changes its inputs only on falling edges, and after every reset it waits three cycles before the first request. With the default 16 slots, a 4-bit wired input can never reach the clamp case. A second instance with 12 slots therefore shares the same stimulus, so that wired values from 12 to 15 exercise the clamp and a non-power-of-two divisor.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/tlbr_rst_sync.sv
module tlbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/tlbr_lcg.sv
module tlbr_lcg #(
  parameter int          SEED_W   = 32,
  parameter int unsigned SEED_MUL = 314159,
  parameter int unsigned SEED_INC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [SEED_W-1:0] seed_nx_o
);
  localparam logic [SEED_W-1:0] MUL_V = SEED_W'(SEED_MUL);
  localparam logic [SEED_W-1:0] INC_V = SEED_W'(SEED_INC);

  logic [SEED_W-1:0] seed_q, seed_d, seed_adv;

  // wrapping multiply-add, truncated to the state width
  always_comb begin
    seed_adv = seed_q * MUL_V + INC_V;
    seed_d   = step_i ? seed_adv : seed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seed_q <= '0;
    else if (step_i) seed_q <= seed_d;
  end

  assign seed_o    = seed_q;
  assign seed_nx_o = seed_adv;
endmodule

// File: rtl/tlbr_remdiv.sv
module tlbr_remdiv
  import tlbr_pkg::*;
#(
  parameter int NUM_W = 16,
  parameter int DEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DEN_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(NUM_W - 1);

  rd_state_e        st_q, st_d;
  logic [NUM_W-1:0] num_q, num_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [DEN_W-1:0] rem_q, rem_d, rem_step;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEN_W:0]   trial;
  logic             fits, last;

  // one restoring step: bring in the next dividend bit, subtract if it fits
  always_comb begin
    trial    = {rem_q, num_q[NUM_W-1]};
    fits     = trial >= {1'b0, den_q};
    rem_step = fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
    last     = (st_q == RD_RUN) && (cnt_q == LAST_C);
  end

  always_comb begin
    st_d  = st_q;
    num_d = num_q;
    den_d = den_q;
    rem_d = rem_q;
    cnt_d = cnt_q;
    unique case (st_q)
      RD_IDLE: if (load_i) begin
        st_d  = RD_RUN;
        num_d = num_i;
        den_d = den_i;
        rem_d = '0;
        cnt_d = '0;
      end
      RD_RUN: begin
        num_d = {num_q[NUM_W-2:0], 1'b0};
        rem_d = rem_step;
        cnt_d = cnt_q + 1'b1;
        if (last) st_d = RD_IDLE;
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RD_IDLE;
      num_q <= '0;
      den_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      num_q <= num_d;
      den_q <= den_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (st_q == RD_RUN);
  assign done_o = last;
  assign rem_o  = rem_step;
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx #(
  parameter int          N_ENTRIES  = 16,
  parameter int          WIRED_W    = 4,
  parameter int          SEED_W     = 32,
  parameter int unsigned SEED_MUL   = 314159,
  parameter int unsigned SEED_INC   = 1,
  parameter int          SEED_SHIFT = 16,
  localparam int         IDX_W      = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [WIRED_W-1:0] wired_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o,
  output logic               busy_o
);
  localparam int NUM_W = SEED_W - SEED_SHIFT;
  localparam int DEN_W = IDX_W + 1;
  localparam int CMP_W = ((WIRED_W > DEN_W) ? WIRED_W : DEN_W) + 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_ENTRIES - 1);

  logic               rst_s_n;
  logic               accept, done, over_floor;
  logic [SEED_W-1:0]  seed_cur, seed_nx;
  logic [DEN_W-1:0]   den, rem;
  logic [WIRED_W-1:0] wired_q, wired_d;
  logic               clamp_q, clamp_d;
  logic [IDX_W-1:0]   idx_q, idx_d, result;
  logic               valid_q, valid_d;
  logic [CMP_W-1:0]   sum;

  tlbr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // the clamp path exists only when the wired input can reach the slot count
  if (2 ** WIRED_W > N_ENTRIES) begin : g_clamp
    assign over_floor = CMP_W'(wired_i) >= CMP_W'(N_ENTRIES);
  end else begin : g_noclamp
    assign over_floor = 1'b0;
  end

  assign accept = req_i & ~busy_o;
  assign den    = over_floor ? DEN_W'(1)
                             : DEN_W'(CMP_W'(N_ENTRIES) - CMP_W'(wired_i));

  tlbr_lcg #(
    .SEED_W   (SEED_W),
    .SEED_MUL (SEED_MUL),
    .SEED_INC (SEED_INC)
  ) u_lcg (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .step_i    (accept),
    .seed_o    (seed_cur),
    .seed_nx_o (seed_nx)
  );

  tlbr_remdiv #(
    .NUM_W (NUM_W),
    .DEN_W (DEN_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load_i (accept),
    .num_i  (seed_nx[SEED_W-1:SEED_SHIFT]),
    .den_i  (den),
    .busy_o (busy_o),
    .done_o (done),
    .rem_o  (rem)
  );

  always_comb begin
    sum     = CMP_W'(rem) + CMP_W'(wired_q);
    result  = clamp_q ? TOP_IDX : IDX_W'(sum);
    wired_d = accept ? wired_i : wired_q;
    clamp_d = accept ? over_floor : clamp_q;
    idx_d   = done ? result : idx_q;
    valid_d = done;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wired_q <= '0;
      clamp_q <= 1'b0;
    end else if (accept) begin
      wired_q <= wired_d;
      clamp_q <= clamp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)  idx_q <= '0;
    else if (done) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) valid_q <= 1'b0;
    else          valid_q <= valid_d;
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tlb_rand_idx_chk.sv
module tlb_rand_idx_chk #(
  parameter int N_ENTRIES = 16,
  parameter int WIRED_W   = 4,
  parameter int IDX_W     = 4,
  parameter int SEED_W    = 32,
  parameter int LAT       = 16
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic               req_i,
  input logic               busy_o,
  input logic               valid_o,
  input logic [IDX_W-1:0]   idx_o,
  input logic [WIRED_W-1:0] wired_q,
  input logic [SEED_W-1:0]  seed_cur
);
  localparam int CW = $clog2(LAT + 2) + 1;
  logic [CW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                lat_q <= '0;
    else if (req_i && !busy_o)   lat_q <= '0;
    else if (busy_o)             lat_q <= lat_q + 1'b1;
  end

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_o && (int'(wired_q) < N_ENTRIES)) |->
      ((int'(idx_o) >= int'(wired_q)) && (int'(idx_o) < N_ENTRIES)));

  // R7
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_o && (int'(wired_q) >= N_ENTRIES)) |-> (int'(idx_o) == N_ENTRIES - 1));

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_o |=> !valid_o);

  // R5
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_o |-> (lat_q == CW'(LAT)));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_i && !busy_o) |=> busy_o);

  // R9
  idle_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_o |-> !busy_o);

  // R6
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_o |=> $stable(seed_cur));

  // R2
  hold_without_req_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_i |=> $stable(seed_cur));
endmodule

bind tlb_rand_idx tlb_rand_idx_chk #(
  .N_ENTRIES (N_ENTRIES),
  .WIRED_W   (WIRED_W),
  .IDX_W     (IDX_W),
  .SEED_W    (SEED_W),
  .LAT       (SEED_W - SEED_SHIFT)
) u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .req_i    (req_i),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .idx_o    (idx_o),
  .wired_q  (wired_q),
  .seed_cur (seed_cur)
);

// File: tb/tb_tlb_rand_idx.sv
`timescale 1ns/1ps
module tb_tlb_rand_idx;
  localparam int NA = 16;
  localparam int NB = 12;
  localparam int LATENCY = 16;

  // vector: {change wired while busy, request while busy, wired[3:0]}
  localparam int NVEC = 16;
  localparam logic [5:0] VEC [NVEC] = '{
    6'h00, 6'h05, 6'h0F, 6'h0C, 6'h1B, 6'h0D, 6'h01, 6'h2E,
    6'h03, 6'h08, 6'h1E, 6'h0B, 6'h37, 6'h02, 6'h0F, 6'h09
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [3:0] wired = '0;
  logic [3:0] idx_a, idx_b;
  logic       valid_a, valid_b, busy_a, busy_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done_all = 0;
  logic [31:0] mseed;

  always #10 clk = ~clk;

  tlb_rand_idx #(.N_ENTRIES(NA)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wired_i(wired),
    .idx_o(idx_a), .valid_o(valid_a), .busy_o(busy_a));

  tlb_rand_idx #(.N_ENTRIES(NB)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wired_i(wired),
    .idx_o(idx_b), .valid_o(valid_b), .busy_o(busy_b));

  function automatic int expect_idx(logic [31:0] s, int w, int n);
    int unsigned v;
    v = s >> 16;
    if (w >= n) return n - 1;
    return int'(v % unsigned'(n - w)) + w;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mseed = '0;
  endtask

  // issue one request; poke = request again while busy, chg = alter wired while busy
  task automatic run_req(logic [3:0] w, bit poke, bit chg, string tag);
    int k;
    @(negedge clk);
    req   = 1'b1;
    wired = w;
    @(negedge clk);
    req = 1'b0;
    mseed = mseed * 32'd314159 + 32'd1;
    check({tag, " R9 busy after accept"}, int'(busy_a), 1);
    k = 0;
    while (!valid_a && k < 40) begin
      if (poke && k == 2) req = 1'b1;
      if (k == 3)         req = 1'b0;
      if (chg && k == 2)  wired = ~w;
      @(negedge clk);
      k++;
    end
    check({tag, " R5 latency"}, k, LATENCY);
    check({tag, " R5 second instance in step"}, int'(valid_b), 1);
    check({tag, " R9 idle on result"}, int'(busy_a), 0);
    check({tag, " R3 R4 R8 index N=16"}, int'(idx_a), expect_idx(mseed, int'(w), NA));
    check({tag, " R3 R7 index N=12"}, int'(idx_b), expect_idx(mseed, int'(w), NB));
    @(negedge clk);
    check({tag, " R5 single pulse"}, int'(valid_a), 0);
    check({tag, " R6 no extra result"}, int'(busy_a), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done_all) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 valid in reset", int'(valid_a), 0);
    check("R1 busy in reset", int'(busy_a), 0);
    check("R1 idx in reset", int'(idx_a), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mseed = '0;

    // R1: first request after reset returns the wired floor
    run_req(4'd5, 1'b0, 1'b0, "R1 first");
    check("R1 first equals floor", int'(idx_a), 5);

    // R2 R3: table walk, the model seed carries over between vectors
    for (int i = 0; i < NVEC; i++) begin
      run_req(VEC[i][3:0], VEC[i][4], VEC[i][5], "R2 vec");
    end

    // R1: reset in the middle of a reduction restarts the state
    @(negedge clk);
    req = 1'b1; wired = 4'd3;
    @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    do_reset();
    check("R1 busy cleared", int'(busy_a), 0);
    run_req(4'd9, 1'b0, 1'b0, "R1 restart");
    check("R1 restart equals floor", int'(idx_a), 9);

    // R7: clamp corners on the 12-slot instance, R6 poke on top
    run_req(4'd12, 1'b1, 1'b0, "R7 w12");
    run_req(4'd15, 1'b0, 1'b1, "R7 w15");
    run_req(4'd11, 1'b0, 1'b0, "R3 single slot");
    check("R3 single slot N=12", int'(idx_b), 11);

    done_all = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule